// File: doc/BRIEF.md
# Extended Interrupt Routing Controller

This block gathers a wide bank of level-sensitive interrupt sources and presents them to a set of processor cores. Each core has a small number of parent interrupt lines. Sources are handled in groups of 32. Each group has an enable word, and a pin-select byte picks which parent line of the target core the group drives. The target core of each source is not chosen inside the block. It arrives already decoded, as a per-source core index from a companion route table. Changing that index moves a live source to its new core in the same cycle.

For every source the block keeps three things: the raw input level, the enable bit, and a live bit. The live bit means the source has been delivered and not yet retired. A source becomes live on a rising input while it is enabled. It also becomes live when software enables a source that is already pending. A source stops being live when its input falls, when it is disabled, or when its target core acknowledges it with a write-one-to-clear to its status word. Each parent line is the OR of all live sources routed to that core and pin.

Software reaches the block over a 32-bit register port with a valid/ready request, byte strobes and a requester-ID sideband. Read data returns one cycle after acceptance. The requester ID selects whose status words a status access sees. Two further register banks are plain storage that software can read back. They have no effect on routing.

Top module: `irq_route_ctrl`

## Requirements
- R1: Each source's raw input level is recorded every cycle whether or not it is enabled. A source that was raised while disabled is still seen as pending when it is later enabled.
- R2: A rising input on a disabled source sets no status bit and changes no parent line. A parent line only rises in the cycle after one of these: an accepted write, a rising input, or a change of the core index input.
- R3: Enable words are at byte address 0x00 + 4*g for group g, with bit b controlling source 32g+b. A write that turns a bit from 0 to 1 delivers that source if its input is high. A write that turns a bit from 1 to 0 retires it. Either effect is visible in the cycle after the write is accepted.
- R4: Status words are at byte address 0x80 + 4*g. A read returns bit b set when source 32g+b is live and its core index equals the requester ID of the read.
- R5: A status write clears the live bit of each source whose written bit is 1 and whose core index equals the requester ID. The source stays cleared while its input stays high, and a new rising input delivers it again. Bits written as 0, and sources of other cores, are unchanged.
- R6: Parent line index c*4+p is high exactly when at least one live source is routed to core c and pin p. It stays high until the last such source is retired. A falling input retires its source.
- R7: Pin-select bytes are at byte addresses 0x20 to 0x27, one byte per group, packed little-endian. Byte g selects the pin for group g. The pin is the index of the lowest set bit of the byte. A zero byte, or a lowest set bit at index 4 or above, selects pin 0.
- R8: Storage words at 0x40 + 4*g and 0x60 + 4*g read back what was written and never change any parent line.
- R9: The following accesses are unmapped: byte addresses 0x28 to 0x3F, byte addresses 0xA0 and above, and any address whose low two bits are not zero. An unmapped read returns 0. An unmapped write changes no state.
- R10: Changing a live source's core index moves its parent line and its status bit to the new core in the same cycle.
- R11: Byte strobe bit k limits a write to data bits 8k+7 down to 8k. Bytes whose strobe is clear keep their old value.
- R12: In the idle state a request is accepted at once (ready high). The block then spends exactly one cycle in the response state, with valid response high and ready low. It then returns to idle. Reads return data in that response cycle, and writes return 0.
- R13: After reset every enable, pending, live, pin-select and storage bit is 0, every parent line is low, ready is high and the response is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_IRQ | Level-sensitive interrupt sources |
| irq_core | input | NUM_IRQ*CORE_W | Per-source target core index, source i at bits i*CORE_W upward |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte strobes for a write |
| req_id | input | CORE_W | Requester ID of the access |
| rsp_valid | output | 1 | Response cycle, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| irq_out | output | NUM_CORE*NUM_PIN | Parent lines, index core*NUM_PIN+pin |

## Verification
The assertions assume that irq_in and irq_core change only between clock edges and hold steady and known from reset onward. They also assume that a request stays stable while it is being offered. The bench drives every input on the falling edge, keeps all sources low and all indices at core 0 through reset, and never raises a source in the same cycle as a write that touches that source. This last rule keeps the ordering of simultaneous set and clear events out of every expected value. The bench also moves irq_core only while no register request is in flight, so each parent-line rise has exactly one cause.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef enum logic [2:0] {
        RGN_ENABLE = 3'd0,
        RGN_PINMAP = 3'd1,
        RGN_BOUNCE = 3'd2,
        RGN_NODE   = 3'd3,
        RGN_STATUS = 3'd4,
        RGN_VOID5  = 3'd5,
        RGN_VOID6  = 3'd6,
        RGN_VOID7  = 3'd7
    } region_e;

    // Pin chosen by a select byte: lowest set bit, out of range or empty -> 0.
    function automatic int unsigned lowest_pin(input logic [7:0] sel, input int unsigned npin);
        int unsigned r;
        bit found;
        r = 0;
        found = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (!found && sel[k]) begin
                r = k;
                found = 1'b1;
            end
        end
        if (!found || r >= npin) r = 0;
        return r;
    endfunction

    function automatic logic [31:0] strobe_mask(input logic [3:0] strb);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{strb[k]}};
        return m;
    endfunction

endpackage

// File: rtl/irq_route_group.sv
module irq_route_group #(
    parameter int GW     = 32,
    parameter int CORE_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GW-1:0]        irq_in,
    input  logic [GW*CORE_W-1:0] core_sel,
    input  logic [CORE_W-1:0]    sel_id,
    input  logic                 en_we,
    input  logic                 ist_we,
    input  logic [GW-1:0]        wdata,
    input  logic [GW-1:0]        wmask,
    output logic [GW-1:0]        en_q,
    output logic [GW-1:0]        pend_q,
    output logic [GW-1:0]        live_q,
    output logic [GW-1:0]        view
);

    logic [GW-1:0] match;
    logic [GW-1:0] en_nx;
    logic [GW-1:0] rise;
    logic [GW-1:0] fall;
    logic [GW-1:0] set_v;
    logic [GW-1:0] clr_v;

    always_comb begin
        for (int i = 0; i < GW; i++) begin
            match[i] = (core_sel[i*CORE_W +: CORE_W] == sel_id);
        end
    end

    always_comb begin
        en_nx = en_we ? ((en_q & ~wmask) | (wdata & wmask)) : en_q;
        rise  = irq_in & ~pend_q;
        fall  = ~irq_in & pend_q;
        // delivery: a new edge on an enabled source, or an enable edge replaying a held level
        set_v = (rise & en_q) | (en_nx & ~en_q & pend_q);
        // retirement wins over delivery in the same cycle
        clr_v = fall | (en_q & ~en_nx) | (ist_we ? (wdata & wmask & match) : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            live_q <= '0;
        end else begin
            en_q   <= en_nx;
            pend_q <= irq_in;
            live_q <= (live_q | set_v) & ~clr_v;
        end
    end

    assign view = live_q & match;

endmodule

// File: rtl/irq_route_pinmap.sv
module irq_route_pinmap
    import irq_route_pkg::*;
#(
    parameter int NUM_GRP = 8,
    parameter int NUM_PIN = 4,
    localparam int SUB_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int PIN_W     = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1,
    localparam int MAP_WORDS = (NUM_GRP + 3) / 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [SUB_W-1:0]         sub,
    input  logic [31:0]              wdata,
    input  logic [3:0]               wstrb,
    output logic [31:0]              rword,
    output logic [NUM_GRP*PIN_W-1:0] grp_pin
);

    logic [7:0] map_q [NUM_GRP];
    logic       sub_ok;

    assign sub_ok = (32'(sub) < MAP_WORDS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GRP; g++) map_q[g] <= '0;
        end else if (we && sub_ok) begin
            for (int k = 0; k < 4; k++) begin
                if (wstrb[k] && (int'(sub) * 4 + k) < NUM_GRP) begin
                    map_q[int'(sub) * 4 + k] <= wdata[8*k +: 8];
                end
            end
        end
    end

    always_comb begin
        rword = '0;
        if (sub_ok) begin
            for (int k = 0; k < 4; k++) begin
                if ((int'(sub) * 4 + k) < NUM_GRP) rword[8*k +: 8] = map_q[int'(sub) * 4 + k];
            end
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pin
        assign grp_pin[g*PIN_W +: PIN_W] = PIN_W'(lowest_pin(map_q[g], NUM_PIN));
    end

endmodule

// File: rtl/irq_route_aggr.sv
module irq_route_aggr #(
    parameter int NUM_IRQ  = 256,
    parameter int NUM_CORE = 4,
    parameter int NUM_PIN  = 4,
    parameter int GW       = 32,
    localparam int NUM_GRP = NUM_IRQ / GW,
    localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
    localparam int PIN_W   = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1
) (
    input  logic [NUM_IRQ-1:0]          live,
    input  logic [NUM_IRQ*CORE_W-1:0]   core_sel,
    input  logic [NUM_GRP*PIN_W-1:0]    grp_pin,
    output logic [NUM_CORE*NUM_PIN-1:0] lines
);

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
            logic [NUM_IRQ-1:0] hit;
            always_comb begin
                for (int i = 0; i < NUM_IRQ; i++) begin
                    hit[i] = live[i]
                           && (core_sel[i*CORE_W +: CORE_W] == CORE_W'(c))
                           && (grp_pin[(i / GW)*PIN_W +: PIN_W] == PIN_W'(p));
                end
            end
            assign lines[c*NUM_PIN + p] = |hit;
        end
    end

endmodule

// File: rtl/irq_route_bus.sv
module irq_route_bus
    import irq_route_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] rd_word,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wr_fire
);

    bus_state_e st_q, st_d;
    logic       fire;

    // next state: IDLE --accept--> RESP --always--> IDLE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: if (req_valid) st_d = BUS_RESP;
            BUS_RESP: st_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (st_q)
            BUS_IDLE: req_ready = 1'b1;
            BUS_RESP: rsp_valid = 1'b1;
        endcase
    end

    assign fire    = req_valid & req_ready;
    assign wr_fire = fire & req_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rsp_rdata <= '0;
        else if (fire) rsp_rdata <= req_write ? '0 : rd_word;
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_IRQ  = 256,
    parameter int NUM_CORE = 4,
    parameter int NUM_PIN  = 4,
    localparam int GW       = 32,
    localparam int NUM_GRP  = NUM_IRQ / GW,
    localparam int SUB_W    = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int ADDR_W   = SUB_W + 5,
    localparam int CORE_W   = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
    localparam int PIN_W    = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1,
    localparam int NUM_LINE = NUM_CORE * NUM_PIN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        irq_in,
    input  logic [NUM_IRQ*CORE_W-1:0] irq_core,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [31:0]               req_wdata,
    input  logic [3:0]                req_wstrb,
    input  logic [CORE_W-1:0]         req_id,
    output logic                      rsp_valid,
    output logic [31:0]               rsp_rdata,
    output logic [NUM_LINE-1:0]       irq_out
);

    logic [SUB_W-1:0]         sub;
    region_e                  rgn;
    logic                     aligned;
    logic                     wr_fire;
    logic [31:0]              wmask;
    logic [31:0]              rd_word;
    logic [31:0]              map_word;
    logic [NUM_GRP-1:0]       en_we;
    logic [NUM_GRP-1:0]       ist_we;
    logic                     map_we;
    logic [NUM_IRQ-1:0]       en_q;
    logic [NUM_IRQ-1:0]       pend_q;
    logic [NUM_IRQ-1:0]       live_q;
    logic [NUM_IRQ-1:0]       view_q;
    logic [NUM_GRP*PIN_W-1:0] grp_pin;
    logic [NUM_LINE-1:0]      lines;
    logic [31:0]              bounce_q [NUM_GRP];
    logic [31:0]              node_q   [NUM_GRP];

    assign sub     = req_addr[2 +: SUB_W];
    assign rgn     = region_e'(req_addr[ADDR_W-1 -: 3]);
    assign aligned = (req_addr[1:0] == 2'b00);
    assign wmask   = strobe_mask(req_wstrb);
    assign map_we  = wr_fire && aligned && (rgn == RGN_PINMAP);

    irq_route_bus #(.DATA_W(32)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .rd_word   (rd_word),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .wr_fire   (wr_fire)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign en_we[g]  = wr_fire && aligned && (rgn == RGN_ENABLE) && (sub == SUB_W'(g));
        assign ist_we[g] = wr_fire && aligned && (rgn == RGN_STATUS) && (sub == SUB_W'(g));

        irq_route_group #(.GW(GW), .CORE_W(CORE_W)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_in   (irq_in[g*GW +: GW]),
            .core_sel (irq_core[g*GW*CORE_W +: GW*CORE_W]),
            .sel_id   (req_id),
            .en_we    (en_we[g]),
            .ist_we   (ist_we[g]),
            .wdata    (req_wdata),
            .wmask    (wmask),
            .en_q     (en_q[g*GW +: GW]),
            .pend_q   (pend_q[g*GW +: GW]),
            .live_q   (live_q[g*GW +: GW]),
            .view     (view_q[g*GW +: GW])
        );
    end

    irq_route_pinmap #(.NUM_GRP(NUM_GRP), .NUM_PIN(NUM_PIN)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (map_we),
        .sub     (sub),
        .wdata   (req_wdata),
        .wstrb   (req_wstrb),
        .rword   (map_word),
        .grp_pin (grp_pin)
    );

    irq_route_aggr #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN), .GW(GW)) u_aggr (
        .live     (live_q),
        .core_sel (irq_core),
        .grp_pin  (grp_pin),
        .lines    (lines)
    );

    // plain storage banks: readable, never consulted by routing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                bounce_q[g] <= '0;
                node_q[g]   <= '0;
            end
        end else if (wr_fire && aligned) begin
            if (rgn == RGN_BOUNCE) bounce_q[sub] <= (bounce_q[sub] & ~wmask) | (req_wdata & wmask);
            if (rgn == RGN_NODE)   node_q[sub]   <= (node_q[sub] & ~wmask) | (req_wdata & wmask);
        end
    end

    always_comb begin
        rd_word = '0;
        if (aligned) begin
            case (rgn)
                RGN_ENABLE: rd_word = en_q[int'(sub)*GW +: GW];
                RGN_PINMAP: rd_word = map_word;
                RGN_BOUNCE: rd_word = bounce_q[sub];
                RGN_NODE:   rd_word = node_q[sub];
                RGN_STATUS: rd_word = view_q[int'(sub)*GW +: GW];
                default:    rd_word = '0;
            endcase
        end
    end

    assign irq_out = lines;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int NUM_IRQ  = 256,
    parameter int NUM_LINE = 16,
    parameter int CORE_W   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic                      req_write,
    input logic                      rsp_valid,
    input logic [NUM_IRQ-1:0]        irq_in,
    input logic [NUM_IRQ*CORE_W-1:0] irq_core,
    input logic [NUM_LINE-1:0]       irq_out,
    input logic [NUM_IRQ-1:0]        pend_q,
    input logic [NUM_IRQ-1:0]        en_q,
    input logic [NUM_IRQ-1:0]        live_q
);

    assert_accept_responds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_single_beat_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_live_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q & ~(pend_q & en_q)) == '0);

    assert_fall_retires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q & $past(pend_q & ~irq_in)) == '0);

    assert_line_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~$past(irq_out)) != '0) |->
            ($past(req_valid && req_ready && req_write)
             || $past(|(irq_in & ~pend_q))
             || (irq_core != $past(irq_core))));

endmodule

bind irq_route_ctrl irq_route_chk #(
    .NUM_IRQ  (NUM_IRQ),
    .NUM_LINE (NUM_LINE),
    .CORE_W   (CORE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .irq_in    (irq_in),
    .irq_core  (irq_core),
    .irq_out   (irq_out),
    .pend_q    (pend_q),
    .en_q      (en_q),
    .live_q    (live_q)
);

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] irq_in = '0;
    logic [511:0] irq_core = '0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [7:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [3:0]   req_wstrb = '0;
    logic [1:0]   req_id = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic [15:0]  irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_route_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .irq_core  (irq_core),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_wstrb (req_wstrb),
        .req_id    (req_id),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .irq_out   (irq_out)
    );

    // {select byte, expected core-0 lines}
    localparam logic [11:0] VECS [10] = '{
        12'h011, 12'h022, 12'h044, 12'h088, 12'h101,
        12'h001, 12'h062, 12'h0C4, 12'h801, 12'h0A2
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [3:0] s, input logic [1:0] id, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_wstrb = s;
        req_id    = id;
        @(negedge clk);
        chk("R12 response valid", 32'(rsp_valid), 32'd1);
        chk("R12 ready low in response", 32'(req_ready), 32'd0);
        rd = rsp_rdata;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s, input logic [1:0] id);
        logic [31:0] dummy;
        bus(1'b1, a, d, s, id, dummy);
    endtask

    task automatic rd32(input logic [7:0] a, input logic [1:0] id, output logic [31:0] v);
        bus(1'b0, a, 32'h0, 4'h0, id, v);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R12 watchdog actual=hung expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        chk("R13 lines low", 32'(irq_out), 32'h0);
        chk("R13 ready high", 32'(req_ready), 32'd1);
        chk("R13 response idle", 32'(rsp_valid), 32'd0);
        rd32(8'h00, 2'd0, v);
        chk("R13 enable word zero", v, 32'h0);
        step();
        chk("R12 back to idle", 32'(req_ready), 32'd1);

        // R2 rise while disabled
        irq_in[5] = 1'b1;
        step();
        chk("R2 disabled rise no line", 32'(irq_out), 32'h0);
        rd32(8'h80, 2'd0, v);
        chk("R2 disabled rise no status", v, 32'h0);

        // R1 / R3 enable replays held level
        wr32(8'h00, 32'h20, 4'hF, 2'd0);
        chk("R1 R3 replay raises line", 32'(irq_out), 32'h1);
        rd32(8'h80, 2'd0, v);
        chk("R4 status shows source 5", v, 32'h20);
        wr32(8'h00, 32'h0, 4'hF, 2'd0);
        chk("R3 disable drops line", 32'(irq_out), 32'h0);
        rd32(8'h80, 2'd0, v);
        chk("R3 disable clears status", v, 32'h0);

        // R11 byte strobes
        wr32(8'h00, 32'hFFFF_FFFF, 4'h1, 2'd0);
        chk("R11 low byte enable replays", 32'(irq_out), 32'h1);
        rd32(8'h00, 2'd0, v);
        chk("R11 only low byte written", v, 32'h0000_00FF);
        wr32(8'h00, 32'h0, 4'h2, 2'd0);
        rd32(8'h00, 2'd0, v);
        chk("R11 unstrobed byte kept", v, 32'h0000_00FF);

        // R6 aggregation
        irq_in[7] = 1'b1;
        step();
        chk("R6 two sources line high", 32'(irq_out), 32'h1);
        irq_in[5] = 1'b0;
        step();
        chk("R6 line holds for last source", 32'(irq_out), 32'h1);
        rd32(8'h80, 2'd0, v);
        chk("R6 fall retires source 5", v, 32'h80);
        irq_in[7] = 1'b0;
        step();
        chk("R6 last fall drops line", 32'(irq_out), 32'h0);

        // R4 requester selection, source 40 on core 2
        irq_core[80 +: 2] = 2'd2;
        wr32(8'h04, 32'h100, 4'hF, 2'd0);
        irq_in[40] = 1'b1;
        step();
        chk("R4 core 2 pin 0 line", 32'(irq_out), 32'h0100);
        rd32(8'h84, 2'd2, v);
        chk("R4 status for owner", v, 32'h100);
        rd32(8'h84, 2'd0, v);
        chk("R4 status for other core", v, 32'h0);

        // R5 write-one-to-clear
        wr32(8'h84, 32'h100, 4'hF, 2'd0);
        chk("R5 other core clear ignored", 32'(irq_out), 32'h0100);
        wr32(8'h84, 32'h0, 4'hF, 2'd2);
        chk("R5 zero bits ignored", 32'(irq_out), 32'h0100);
        wr32(8'h84, 32'h100, 4'hF, 2'd2);
        chk("R5 clear drops line", 32'(irq_out), 32'h0);
        rd32(8'h84, 2'd2, v);
        chk("R5 stays clear while high", v, 32'h0);
        irq_in[40] = 1'b0;
        step();
        irq_in[40] = 1'b1;
        step();
        chk("R5 new edge redelivers", 32'(irq_out), 32'h0100);

        // R10 retarget
        irq_core[80 +: 2] = 2'd3;
        #1;
        chk("R10 line moves same cycle", 32'(irq_out), 32'h1000);
        step();
        rd32(8'h84, 2'd3, v);
        chk("R10 status moves", v, 32'h100);

        // R8 storage banks
        wr32(8'h44, 32'hA5A5_0F0F, 4'hF, 2'd0);
        rd32(8'h44, 2'd0, v);
        chk("R8 bounce readback", v, 32'hA5A5_0F0F);
        wr32(8'h64, 32'h1234_5678, 4'hF, 2'd0);
        rd32(8'h64, 2'd0, v);
        chk("R8 node readback", v, 32'h1234_5678);
        chk("R8 lines unchanged", 32'(irq_out), 32'h1000);
        irq_in[40] = 1'b0;
        step();
        chk("R6 retire after retarget", 32'(irq_out), 32'h0);

        // R7 pin-select table, source 0 on core 0
        irq_in[0] = 1'b1;
        step();
        for (int i = 0; i < 10; i++) begin
            wr32(8'h20, {24'h0, VECS[i][11:4]}, 4'hF, 2'd0);
            chk($sformatf("R7 select byte %h", VECS[i][11:4]), 32'(irq_out), {28'h0, VECS[i][3:0]});
        end

        // R9 unmapped accesses
        wr32(8'h28, 32'hFFFF_FFFF, 4'hF, 2'd0);
        rd32(8'h28, 2'd0, v);
        chk("R9 unused select word reads 0", v, 32'h0);
        rd32(8'h20, 2'd0, v);
        chk("R9 select word untouched", v, 32'h0000_000A);
        wr32(8'hA0, 32'hFFFF_FFFF, 4'hF, 2'd0);
        rd32(8'hA0, 2'd0, v);
        chk("R9 high region reads 0", v, 32'h0);
        wr32(8'h01, 32'h0, 4'hF, 2'd0);
        rd32(8'h00, 2'd0, v);
        chk("R9 misaligned write ignored", v, 32'h0000_00FF);
        chk("R9 lines unchanged", 32'(irq_out), 32'h0002);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule